// File: doc/BRIEF.md
# Three-Phase Apparent Energy Accumulator

This block builds up volt-ampere energy for phases A, B and C. Per-phase rms voltage and rms current values arrive together on one sample strobe. A two-bit product-mode field decides how each phase's volt-ampere product is formed. One mode replaces the phase B voltage with the mean of the phase A and phase C voltages. A shared current gain is applied in every mode except the raw one. Each product is then scaled by that phase's own apparent-power gain and added to the phase's accumulator.

By default the accumulators run freely, and they saturate instead of wrapping around. In line-cycle mode, energy is instead summed over a programmed number of zero-crossing pulses. When the last pulse of that count arrives, the total is copied into the visible per-phase outputs. A one-cycle done pulse marks this, and the internal sums and the pulse counter restart on the same clock edge. Rms computation and zero-crossing detection are done upstream. Software access to the values is handled outside the block.

Top module: `apparent_energy_acc`

## Requirements
- R1: After reset, all three energy outputs read 0 and `lc_done` is low.
- R2: In mode 2'b00, each phase adds floor(V·I·G/1024), using its own rms voltage V, its own raw rms current I and its own apparent gain G. `cur_gain` has no effect in this mode.
- R3: In mode 2'b01, phase B uses floor((v_a+v_c)/2) as its voltage. Phases A and C use their own voltages. All three phases use gain-adjusted currents, as defined in R4.
- R4: In mode 2'b10, each phase uses its own voltage and a gain-adjusted current I' = min(floor(I·cur_gain/1024), 2^16−1). Modes 2'b01 and 2'b10 both use this current.
- R5: The apparent gain is unsigned, with 1024 meaning unity. A gain of 512 halves a phase's increment, and a gain of 2048 doubles it.
- R6: In mode 2'b11, a sample changes no accumulator.
- R7: An accumulator that would go above 2^32−1 holds at 2^32−1.
- R8: While `sample_vld` is low, no energy is added.
- R9: With `lc_en` high, the energy outputs show only the latched totals. Those totals change only on the clock edge where the `lc_count`-th zero-crossing pulse is seen. A `lc_count` of 0 counts as 1. The latched total includes any sample taken on that same edge.
- R10: On the edge where a line-cycle period closes, `lc_done` goes high for one cycle. On that same edge, the internal sums clear and the crossing count restarts, so the next period's total starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_vld | input | 1 | Strobe marking a new set of rms values |
| mode | input | 2 | Product selection mode |
| v_a | input | 16 | Phase A rms voltage |
| v_b | input | 16 | Phase B rms voltage |
| v_c | input | 16 | Phase C rms voltage |
| i_a | input | 16 | Phase A rms current |
| i_b | input | 16 | Phase B rms current |
| i_c | input | 16 | Phase C rms current |
| gain_a | input | 12 | Phase A apparent gain, 1024 = unity |
| gain_b | input | 12 | Phase B apparent gain |
| gain_c | input | 12 | Phase C apparent gain |
| cur_gain | input | 12 | Shared current gain, 1024 = unity |
| lc_en | input | 1 | Line-cycle accumulation enable |
| lc_count | input | 8 | Zero crossings per line-cycle period |
| zx_pulse | input | 1 | One-cycle zero-crossing pulse |
| energy_a | output | 32 | Phase A apparent energy |
| energy_b | output | 32 | Phase B apparent energy |
| energy_c | output | 32 | Phase C apparent energy |
| lc_done | output | 1 | One-cycle line-cycle completion pulse |

## Verification
The assertions assume that `lc_en` and `lc_count` are changed only while no zero-crossing pulse is arriving. They also assume reset is applied before any checks. A mode change in the middle of a period is allowed but is not checked.

The bench keeps to these assumptions. Each scenario task first resets the block, then sets the mode and line-cycle controls, and only then sends samples. Strobes and pulses are driven at the falling clock edge, and each lasts exactly one cycle.

// File: rtl/aea_pkg.sv
package aea_pkg;
  typedef enum logic [1:0] {
    AEA_OWN_RAW   = 2'b00,
    AEA_B_AVG     = 2'b01,
    AEA_OWN_IGAIN = 2'b10,
    AEA_RSVD      = 2'b11
  } aea_mode_e;

  localparam int unsigned AEA_PHASES = 3;
endpackage

// File: rtl/aea_product.sv
module aea_product
  import aea_pkg::*;
#(
  parameter int unsigned RMS_W     = 16,
  parameter int unsigned GAIN_W    = 12,
  parameter int unsigned GAIN_FRAC = 10,
  localparam int unsigned INC_W    = 2*RMS_W + GAIN_W - GAIN_FRAC
) (
  input  logic                                 sample_vld,
  input  aea_mode_e                            mode,
  input  logic [AEA_PHASES-1:0][RMS_W-1:0]     v,
  input  logic [AEA_PHASES-1:0][RMS_W-1:0]     i,
  input  logic [AEA_PHASES-1:0][GAIN_W-1:0]    va_gain,
  input  logic [GAIN_W-1:0]                    cur_gain,
  output logic                                 add_en,
  output logic [AEA_PHASES-1:0][INC_W-1:0]     inc
);
  localparam int unsigned CG_W = RMS_W + GAIN_W;
  localparam int unsigned PR_W = 2*RMS_W + GAIN_W;

  function automatic logic [RMS_W-1:0] apply_cur_gain(
    input logic [RMS_W-1:0] cur, input logic [GAIN_W-1:0] g);
    logic [CG_W-1:0] p;
    p = {{GAIN_W{1'b0}}, cur} * {{RMS_W{1'b0}}, g};
    p = p >> GAIN_FRAC;
    if (p > {{GAIN_W{1'b0}}, {RMS_W{1'b1}}}) return '1;
    return p[RMS_W-1:0];
  endfunction

  function automatic logic [INC_W-1:0] va_scale(
    input logic [RMS_W-1:0] vv, input logic [RMS_W-1:0] ii,
    input logic [GAIN_W-1:0] g);
    logic [PR_W-1:0] p;
    p = {{(RMS_W+GAIN_W){1'b0}}, vv} * {{(RMS_W+GAIN_W){1'b0}}, ii}
      * {{(2*RMS_W){1'b0}}, g};
    return p[PR_W-1:GAIN_FRAC];
  endfunction

  logic [RMS_W:0]   vac_sum;
  logic [RMS_W-1:0] vb_avg;

  assign vac_sum = {1'b0, v[0]} + {1'b0, v[2]};
  assign vb_avg  = vac_sum[RMS_W:1];
  assign add_en  = sample_vld && (mode != AEA_RSVD);

  for (genvar p = 0; p < AEA_PHASES; p++) begin : g_ph
    logic [RMS_W-1:0] v_sel;
    logic [RMS_W-1:0] i_sel;
    always_comb begin
      v_sel = v[p];
      if (p == 1 && mode == AEA_B_AVG) v_sel = vb_avg;
      i_sel = (mode == AEA_OWN_RAW) ? i[p] : apply_cur_gain(i[p], cur_gain);
    end
    assign inc[p] = va_scale(v_sel, i_sel, va_gain[p]);
  end
endmodule

// File: rtl/aea_cycle_ctrl.sv
module aea_cycle_ctrl #(
  parameter int unsigned CYC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lc_en,
  input  logic [CYC_W-1:0] lc_count,
  input  logic             zx_pulse,
  output logic             lc_close,
  output logic             lc_done
);
  logic [CYC_W-1:0] zx_cnt;
  logic [CYC_W:0]   zx_next;

  assign zx_next  = {1'b0, zx_cnt} + 1'b1;
  assign lc_close = lc_en && zx_pulse && (zx_next >= {1'b0, lc_count});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zx_cnt  <= '0;
      lc_done <= 1'b0;
    end else begin
      lc_done <= lc_close;
      if (!lc_en || lc_close) zx_cnt <= '0;
      else if (zx_pulse)      zx_cnt <= zx_next[CYC_W-1:0];
    end
  end

  // R10
  count_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lc_done |-> zx_cnt == '0);

  // R9
  idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lc_en |=> zx_cnt == '0);
endmodule

// File: rtl/aea_phase_acc.sv
module aea_phase_acc #(
  parameter int unsigned INC_W = 34,
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_en,
  input  logic [INC_W-1:0] inc,
  input  logic             lc_en,
  input  logic             lc_close,
  output logic [ACC_W-1:0] energy
);
  localparam int unsigned SUM_W = ((ACC_W > INC_W) ? ACC_W : INC_W) + 1;

  function automatic logic [ACC_W-1:0] sat_add(
    input logic [ACC_W-1:0] a, input logic [INC_W-1:0] b);
    logic [SUM_W-1:0] s;
    s = SUM_W'(a) + SUM_W'(b);
    if (s > SUM_W'({ACC_W{1'b1}})) return '1;
    return s[ACC_W-1:0];
  endfunction

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_nxt;
  logic [ACC_W-1:0] latch_q;

  assign acc_nxt = add_en ? sat_add(acc_q, inc) : acc_q;
  assign energy  = lc_en ? latch_q : acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      latch_q <= '0;
    end else if (lc_close) begin
      latch_q <= acc_nxt;
      acc_q   <= '0;
    end else begin
      acc_q <= acc_nxt;
    end
  end

  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lc_close |=> acc_q >= $past(acc_q));

  // R6
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!add_en && !lc_close) |=> $stable(acc_q));

  // R9
  latch_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lc_close |=> $stable(latch_q));
endmodule

// File: rtl/apparent_energy_acc.sv
module apparent_energy_acc
  import aea_pkg::*;
#(
  parameter int unsigned RMS_W     = 16,
  parameter int unsigned GAIN_W    = 12,
  parameter int unsigned GAIN_FRAC = 10,
  parameter int unsigned ACC_W     = 32,
  parameter int unsigned CYC_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_vld,
  input  logic [1:0]        mode,
  input  logic [RMS_W-1:0]  v_a,
  input  logic [RMS_W-1:0]  v_b,
  input  logic [RMS_W-1:0]  v_c,
  input  logic [RMS_W-1:0]  i_a,
  input  logic [RMS_W-1:0]  i_b,
  input  logic [RMS_W-1:0]  i_c,
  input  logic [GAIN_W-1:0] gain_a,
  input  logic [GAIN_W-1:0] gain_b,
  input  logic [GAIN_W-1:0] gain_c,
  input  logic [GAIN_W-1:0] cur_gain,
  input  logic              lc_en,
  input  logic [CYC_W-1:0]  lc_count,
  input  logic              zx_pulse,
  output logic [ACC_W-1:0]  energy_a,
  output logic [ACC_W-1:0]  energy_b,
  output logic [ACC_W-1:0]  energy_c,
  output logic              lc_done
);
  localparam int unsigned INC_W = 2*RMS_W + GAIN_W - GAIN_FRAC;

  logic [AEA_PHASES-1:0][RMS_W-1:0]  v_vec;
  logic [AEA_PHASES-1:0][RMS_W-1:0]  i_vec;
  logic [AEA_PHASES-1:0][GAIN_W-1:0] g_vec;
  logic [AEA_PHASES-1:0][INC_W-1:0]  inc;
  logic [AEA_PHASES-1:0][ACC_W-1:0]  energy;
  logic                              add_en;
  logic                              lc_close;
  aea_mode_e                         mode_e;

  assign mode_e = aea_mode_e'(mode);
  assign v_vec  = {v_c, v_b, v_a};
  assign i_vec  = {i_c, i_b, i_a};
  assign g_vec  = {gain_c, gain_b, gain_a};

  aea_product #(
    .RMS_W(RMS_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)
  ) u_product (
    .sample_vld(sample_vld), .mode(mode_e), .v(v_vec), .i(i_vec),
    .va_gain(g_vec), .cur_gain(cur_gain), .add_en(add_en), .inc(inc)
  );

  aea_cycle_ctrl #(.CYC_W(CYC_W)) u_cycle (
    .clk(clk), .rst_n(rst_n), .lc_en(lc_en), .lc_count(lc_count),
    .zx_pulse(zx_pulse), .lc_close(lc_close), .lc_done(lc_done)
  );

  for (genvar p = 0; p < AEA_PHASES; p++) begin : g_acc
    aea_phase_acc #(.INC_W(INC_W), .ACC_W(ACC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .add_en(add_en), .inc(inc[p]),
      .lc_en(lc_en), .lc_close(lc_close), .energy(energy[p])
    );
  end

  assign energy_a = energy[0];
  assign energy_b = energy[1];
  assign energy_c = energy[2];

  // R6
  rsvd_no_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e == AEA_RSVD) |-> !add_en);

  // R8
  no_strobe_no_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld |-> !add_en);

  // R10
  done_after_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lc_close |=> lc_done);
endmodule

// File: tb/apparent_energy_acc_bench.sv
module apparent_energy_acc_bench;
  localparam int CLK_PERIOD = 10;
  localparam longint SAT = 64'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_vld = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [15:0] v_a = '0, v_b = '0, v_c = '0, i_a = '0, i_b = '0, i_c = '0;
  logic [11:0] gain_a = 12'd1024, gain_b = 12'd1024, gain_c = 12'd1024;
  logic [11:0] cur_gain = 12'd1024;
  logic lc_en = 1'b0;
  logic [7:0] lc_count = 8'd1;
  logic zx_pulse = 1'b0;
  logic [31:0] energy_a, energy_b, energy_c;
  logic lc_done;

  int checks = 0;
  int failures = 0;
  longint exp_e [3];

  apparent_energy_acc u_apparent_energy_acc (
    .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .mode(mode),
    .v_a(v_a), .v_b(v_b), .v_c(v_c), .i_a(i_a), .i_b(i_b), .i_c(i_c),
    .gain_a(gain_a), .gain_b(gain_b), .gain_c(gain_c), .cur_gain(cur_gain),
    .lc_en(lc_en), .lc_count(lc_count), .zx_pulse(zx_pulse),
    .energy_a(energy_a), .energy_b(energy_b), .energy_c(energy_c),
    .lc_done(lc_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bench-side restatement of the requirements
  function automatic longint model_inc(input int ph);
    longint vv, ii, gg;
    vv = (ph == 0) ? v_a : (ph == 1) ? v_b : v_c;
    ii = (ph == 0) ? i_a : (ph == 1) ? i_b : i_c;
    gg = (ph == 0) ? gain_a : (ph == 1) ? gain_b : gain_c;
    if (mode == 2'b11) return 0;
    if (ph == 1 && mode == 2'b01) vv = (longint'(v_a) + longint'(v_c)) / 2;
    if (mode != 2'b00) begin
      ii = (ii * cur_gain) / 1024;
      if (ii > 65535) ii = 65535;
    end
    return (vv * ii * gg) / 1024;
  endfunction

  task automatic model_add();
    for (int p = 0; p < 3; p++) begin
      exp_e[p] = exp_e[p] + model_inc(p);
      if (exp_e[p] > SAT) exp_e[p] = SAT;
    end
  endtask

  task automatic check_all(input string req);
    check(req, energy_a, exp_e[0]);
    check(req, energy_b, exp_e[1]);
    check(req, energy_c, exp_e[2]);
  endtask

  task automatic set_rms(input int va, vb, vc, ia, ib, ic);
    v_a = 16'(va); v_b = 16'(vb); v_c = 16'(vc);
    i_a = 16'(ia); i_b = 16'(ib); i_c = 16'(ic);
  endtask

  task automatic pulse(input logic vld, input logic zx);
    sample_vld = vld;
    zx_pulse = zx;
    @(posedge clk);
    @(negedge clk);
    sample_vld = 1'b0;
    zx_pulse = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    lc_en = 1'b0;
    sample_vld = 1'b0;
    zx_pulse = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int p = 0; p < 3; p++) exp_e[p] = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check_all("R1");
    check("R1", lc_done, 0);
  endtask

  task automatic t_mode_raw();
    do_reset();
    mode = 2'b00; cur_gain = 12'd2048;
    gain_a = 12'd1024; gain_b = 12'd512; gain_c = 12'd2048;
    set_rms(1000, 300, 50000, 200, 400, 3);
    model_add(); pulse(1, 0);
    check_all("R2");
    check("R5", energy_b, 60000);
    check("R2", energy_a, 200000);
    set_rms(7, 11, 13, 17, 19, 23);
    model_add(); pulse(1, 0);
    check_all("R2");
  endtask

  task automatic t_mode_bavg();
    do_reset();
    mode = 2'b01; cur_gain = 12'd1536;
    gain_a = 12'd1024; gain_b = 12'd1024; gain_c = 12'd1024;
    set_rms(1001, 9999, 2000, 100, 100, 100);
    model_add(); pulse(1, 0);
    check("R3", energy_b, 1500 * 150);
    check_all("R3");
  endtask

  task automatic t_mode_igain();
    do_reset();
    mode = 2'b10; cur_gain = 12'd4095;
    gain_a = 12'd1024; gain_b = 12'd1024; gain_c = 12'd1024;
    set_rms(10, 10, 10, 60000, 1000, 5);
    model_add(); pulse(1, 0);
    check("R4", energy_a, 10 * 65535);
    check_all("R4");
  endtask

  task automatic t_mode_rsvd();
    do_reset();
    mode = 2'b00;
    set_rms(100, 100, 100, 100, 100, 100);
    model_add(); pulse(1, 0);
    mode = 2'b11;
    pulse(1, 0);
    pulse(1, 0);
    check_all("R6");
  endtask

  task automatic t_no_strobe();
    do_reset();
    mode = 2'b00;
    set_rms(500, 500, 500, 500, 500, 500);
    pulse(0, 0);
    pulse(0, 1);
    check_all("R8");
  endtask

  task automatic t_saturate();
    do_reset();
    mode = 2'b00;
    gain_a = 12'd4095; gain_b = 12'd1024; gain_c = 12'd1024;
    set_rms(65535, 65535, 1, 65535, 65535, 1);
    model_add(); pulse(1, 0);
    check("R7", energy_a, SAT);
    model_add(); pulse(1, 0);
    check("R7", energy_a, SAT);
    check("R7", energy_b, SAT);
    check_all("R7");
  endtask

  task automatic t_line_cycle();
    longint tot [3];
    do_reset();
    mode = 2'b00;
    gain_a = 12'd1024; gain_b = 12'd1024; gain_c = 12'd1024;
    lc_en = 1'b1; lc_count = 8'd3;
    set_rms(100, 200, 300, 10, 20, 30);
    model_add(); pulse(1, 1);
    model_add(); pulse(1, 0);
    pulse(0, 1);
    check("R9", energy_a, 0);
    check("R10", lc_done, 0);
    model_add(); pulse(1, 1);
    check_all("R9");
    check("R10", lc_done, 1);
    for (int p = 0; p < 3; p++) tot[p] = exp_e[p];
    pulse(0, 0);
    check("R10", lc_done, 0);
    check("R9", energy_c, tot[2]);
    lc_count = 8'd0;
    for (int p = 0; p < 3; p++) exp_e[p] = 0;
    set_rms(5, 6, 7, 8, 9, 10);
    model_add(); pulse(1, 1);
    check_all("R10");
    check("R9", lc_done, 1);
  endtask

  initial begin
    t_reset();
    t_mode_raw();
    t_mode_bavg();
    t_mode_igain();
    t_mode_rsvd();
    t_no_strobe();
    t_saturate();
    t_line_cycle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule